// File: doc/BRIEF.md
# Static Eight-Way Barrier with NAND Reduction

This block synchronizes eight processing elements through one barrier that always spans all of them, and hands each of them a 4-bit aggregate value. Every element drives a 4-bit contribution and a request line. Once all eight requests are high, the block does not release anyone right away. It waits for a programmable settle delay, counted in internal clock cycles, so that the contributions can become stable. It then captures the bitwise NAND of the eight contributions and releases every element at the same moment. A host therefore needs one port cycle to raise its request and one more to read the result and drop the request. The exchanges that confirm the barrier and then clear it run inside the block on its own clock.

A second request line per element gives a start-up barrier that carries no data. Programs use it to bring all elements into step when they begin. Each element also gets a fixed index output, so its software can learn which position it occupies. Each element can see whether it is still waiting or has been released.

A result stays frozen for an element until that element drops its request. No new barrier can begin until all eight elements have dropped their requests.

Top module: `nand_barrier`

## Requirements
- R1: The result bit b is 0 exactly when bit b of every element's contribution is 1. The contribution of element i sits at `pe_data[i*4 +: 4]`.
- R2: After the edge on which the last request makes the set complete, `pe_go` goes to all ones. With the default SETTLE of 4, it is seen after the 5th rising edge (SETTLE+1) and no earlier.
- R3: `pe_go` stays all zero for as long as any element has neither `pe_ready` nor `pe_sync` asserted.
- R4: While released, `result` stays unchanged. Changes on `pe_data` during this time have no effect on it.
- R5: An element's `pe_go` bit clears on the first edge after that element drops its request. A new barrier starts only after every request has been low at the same time, and an element that raises its request again before that is not released.
- R6: When all eight `pe_sync` lines are high, the block runs a start-up barrier with the same timing. It releases everyone and leaves `result` unchanged. If both barrier kinds become complete on the same edge, the start-up barrier takes priority.
- R7: Bit i of `pe_wait` is 1 exactly when element i has a request high and its `pe_go` bit is 0.
- R8: Field i of `pe_id` (`pe_id[i*3 +: 3]`) always holds i.
- R9: After reset, `pe_go` is all zero, `result` is 0, and the block waits for a new barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sequencing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pe_ready | input | 8 | Per-element data barrier request |
| pe_sync | input | 8 | Per-element start-up barrier request |
| pe_data | input | 32 | Per-element 4-bit contributions, element i at bits i*4+3..i*4 |
| result | output | 4 | NAND reduction captured at release |
| pe_go | output | 8 | Per-element release flag |
| pe_wait | output | 8 | Per-element waiting status |
| pe_id | output | 24 | Fixed element index, 3 bits per element |

## Verification
A settle counter that is off by one moves the release edge. The bench counts the cycles from the completing request to release, so this shows up within SETTLE+1 edges of any barrier. A sequencer that leaves the released state too early shows up as a re-raised request that gets `pe_go`, or as a `result` that changes while its holder still has its request high. This appears within one cycle of the stimulus. An error in the reduction, or in which data it samples, shows up as a wrong `result` on the first barrier whose contributions exercise that bit.

// File: rtl/nand_barrier.sv
`timescale 1ns/1ps
module nand_barrier #(
  parameter int NPE    = 8,
  parameter int DW     = 4,
  parameter int SETTLE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPE-1:0]     pe_ready,
  input  logic [NPE-1:0]     pe_sync,
  input  logic [NPE*DW-1:0]  pe_data,
  output logic [DW-1:0]      result,
  output logic [NPE-1:0]     pe_go,
  output logic [NPE-1:0]     pe_wait,
  output logic [NPE*$clog2(NPE)-1:0] pe_id
);
  localparam int IDW = $clog2(NPE);
  localparam int CW  = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_DONE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          is_sync;
  logic [NPE-1:0] req;
  logic [DW-1:0]  nand_val;

  assign req     = pe_ready | pe_sync;
  assign pe_wait = req & ~pe_go;

  for (genvar i = 0; i < NPE; i++) begin : g_id
    assign pe_id[i*IDW +: IDW] = IDW'(i);
  end

  always_comb begin
    logic [DW-1:0] acc;
    acc = '1;
    for (int i = 0; i < NPE; i++) acc = acc & pe_data[i*DW +: DW];
    nand_val = ~acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      is_sync <= 1'b0;
      pe_go   <= '0;
      result  <= '0;
    end else begin
      case (state)
        S_IDLE: if ((&pe_sync) || (&pe_ready)) begin
          state   <= S_SETTLE;
          cnt     <= '0;
          is_sync <= &pe_sync;
        end
        S_SETTLE: if (cnt == CW'(SETTLE - 1)) begin
          state <= S_DONE;
          pe_go <= '1;
          if (!is_sync) result <= nand_val;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: begin
          pe_go <= pe_go & req;
          if (~|req) state <= S_IDLE;
        end
      endcase
    end
  end

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && $past(state) == S_DONE) |-> $stable(result));

  p_go_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|pe_go) |-> ((&pe_go) && $past(state) == S_SETTLE));

  p_go_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_go & $past(pe_go) & ~$past(req)) == '0);

  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_DONE && state != S_DONE) |-> ($past(req) == '0));

  p_sync_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && $past(state) == S_SETTLE && is_sync) |-> $stable(result));
endmodule

// File: tb/nand_barrier_test.sv
`timescale 1ns/1ps
module nand_barrier_test;
  localparam int NPE = 8, DW = 4, SETTLE = 4, IDW = 3;

  logic clk = 0, rst_n = 0;
  logic [NPE-1:0] pe_ready = '0, pe_sync = '0;
  logic [NPE*DW-1:0] pe_data = '0;
  logic [DW-1:0] result;
  logic [NPE-1:0] pe_go, pe_wait;
  logic [NPE*IDW-1:0] pe_id;
  int checks = 0, errors = 0;
  logic [DW-1:0] last_res;

  always #2 clk = ~clk;

  nand_barrier #(.NPE(NPE), .DW(DW), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .pe_ready(pe_ready), .pe_sync(pe_sync),
    .pe_data(pe_data), .result(result), .pe_go(pe_go), .pe_wait(pe_wait),
    .pe_id(pe_id));

  function automatic logic [DW-1:0] exp_nand(input logic [NPE*DW-1:0] d);
    logic [DW-1:0] a = '1;
    for (int i = 0; i < NPE; i++) a &= d[i*DW +: DW];
    return ~a;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic chk_wait(input string r);
    chk(pe_wait == ((pe_ready | pe_sync) & ~pe_go), r, pe_wait, (pe_ready | pe_sync) & ~pe_go);
  endtask

  // after completing request raised at a negedge, count edges to release
  task automatic wait_release(input bit sync_kind, input logic [NPE*DW-1:0] d);
    for (int k = 1; k <= SETTLE + 1; k++) begin
      @(posedge clk); @(negedge clk);
      if (k <= SETTLE) chk(pe_go == '0, "R2 early", pe_go, 0);
      else chk(pe_go == '1, "R2 release", pe_go, 8'hFF);
    end
    if (sync_kind) chk(result == last_res, "R6 result kept", result, last_res);
    else begin
      chk(result == exp_nand(d), "R1 nand", result, exp_nand(d));
      last_res = exp_nand(d);
    end
    chk_wait("R7 released");
  endtask

  task automatic release_all();
    pe_ready = '0; pe_sync = '0;
    @(posedge clk); @(negedge clk);
    chk(pe_go == '0, "R5 cleared", pe_go, 0);
  endtask

  task automatic op_random();
    logic [NPE*DW-1:0] d;
    int order[NPE];
    d = {$urandom(), $urandom()};
    if ($urandom_range(0, 3) == 0) d = '1 ^ (32'h1 << $urandom_range(0, 31));
    pe_data = d;
    for (int i = 0; i < NPE; i++) order[i] = i;
    for (int i = NPE - 1; i > 0; i--) begin
      int j = $urandom_range(0, i);
      int t = order[i]; order[i] = order[j]; order[j] = t;
    end
    for (int i = 0; i < NPE - 1; i++) begin
      pe_ready[order[i]] = 1'b1;
      repeat ($urandom_range(1, 3)) @(negedge clk);
      chk(pe_go == '0, "R3 partial", pe_go, 0);
      chk_wait("R7 waiting");
    end
    pe_ready[order[NPE-1]] = 1'b1;
    wait_release(0, d);
    pe_data = ~d;
    repeat (2) @(negedge clk);
    chk(result == exp_nand(d), "R4 hold", result, exp_nand(d));
    release_all();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    last_res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pe_go == '0, "R9 go", pe_go, 0);
    chk(result == '0, "R9 result", result, 0);
    chk(pe_wait == '0, "R9 wait", pe_wait, 0);
    for (int i = 0; i < NPE; i++)
      chk(pe_id[i*IDW +: IDW] == IDW'(i), "R8 id", pe_id[i*IDW +: IDW], i);

    // directed: all ones -> 0, all zeros -> F
    pe_data = '1; pe_ready = '1; wait_release(0, '1); release_all();
    pe_data = '0; pe_ready = '1; wait_release(0, '0); release_all();

    // seven of eight ready for a long time
    pe_data = 32'h1234_5678; pe_ready = 8'h7F;
    repeat (20) @(negedge clk);
    chk(pe_go == '0, "R3 seven", pe_go, 0);
    pe_ready = '1; wait_release(0, 32'h1234_5678);

    // partial release, re-raise while one holds
    pe_ready = 8'h01;
    @(posedge clk); @(negedge clk);
    chk(pe_go == 8'h01, "R5 per pe", pe_go, 8'h01);
    pe_ready = '1;
    repeat (SETTLE + 4) @(negedge clk);
    chk(pe_go == 8'h01, "R5 no restart", pe_go, 8'h01);
    chk_wait("R7 mixed");
    pe_ready = '0;
    @(posedge clk); @(negedge clk);
    chk(pe_go == '0, "R5 all low", pe_go, 0);
    pe_data = 32'hFFFF_FFF7; pe_ready = '1; wait_release(0, 32'hFFFF_FFF7); release_all();

    // start-up barrier, result untouched
    pe_data = '1; pe_sync = '1; wait_release(1, '1); release_all();
    // both complete together: sync wins
    pe_data = '1; pe_sync = '1; pe_ready = '1; wait_release(1, '1); release_all();

    for (int n = 0; n < 40; n++) op_random();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule